// File: doc/BRIEF.md
# Byte-Partial-Product Multiplier

This block multiplies two unsigned operands of `NB` bytes each (`NB` is 2 or 3) and returns the full product of `2*NB` bytes. It has a single 8x8 unsigned multiplier, which it reuses over every pair of operand bytes, one pair per clock. Each 16-bit byte product is shifted left by `8*(i+j)` bits, where `i` and `j` are the byte indices in operand A and operand B. It is then added into an accumulator as wide as the product. Any carry from that addition ripples up to the top byte.

A user raises `start` for one cycle while `busy` is low. The block captures both operands on that edge, clears the accumulator and runs `NB*NB` accumulate steps. After the last step it pulses `done` for one cycle, and `product` then holds the result until the next accepted start. Because the operands are captured, the operand pins may change once the operation has begun. The captured operand A is never modified.

Top module: `bpp_mult`

## Requirements
- R1: When `done` is high, `product` equals the full unsigned product `opa*opb` of the operands captured at the accepted start, `16*NB` bits wide, with no truncation.
- R2: `done` is high for exactly one cycle, on the `NB*NB`-th rising clock edge after the edge that accepted `start`.
- R3: `busy` rises on the edge that accepts `start`, stays high until the edge that raises `done`, and is low in the cycle where `done` is high and in every idle cycle.
- R4: A `start` pulse while `busy` is high is ignored: it changes neither the result nor the cycle in which `done` appears.
- R5: `opa` and `opb` are sampled only on the edge that accepts `start`; changing them while `busy` is high does not change the result.
- R6: While the block is idle, `product` keeps the last result until the next accepted `start`.
- R7: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R8: All-ones operands give `(2^(8*NB)-1)^2` exactly. No accumulate step ever carries out of the top product byte.
- R9: A zero operand gives a zero product, and an operand of 1 returns the other operand, zero-extended.
- R10: `start` sampled in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to begin a multiply; taken only while `busy` is low |
| opa | input | 8*NB | Multiplicand, captured at start |
| opb | input | 8*NB | Multiplier, captured at start |
| busy | output | 1 | High while partial products are being accumulated |
| done | output | 1 | One-cycle pulse marking a valid `product` |
| product | output | 16*NB | Full unsigned product |

## Verification
Every result is due on the `NB*NB`-th rising edge after the edge that took `start`. When the driver issues an operation, it records that due cycle together with the expected product in the scoreboard entry. The monitor samples on falling edges and checks the `done` pulse against the due cycle as well as the value. In every sampled cycle it also checks `busy` against whether an operation is outstanding. Starts issued while the block is busy, and operand changes during a run, are never queued, so any effect they had would show up as a wrong value or an early or late `done`.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  // Width of one operand byte and of one byte product.
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PP_W   = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PP_W-1:0]   pp_t;
endpackage

// File: rtl/bpp_sched.sv
// Walks the byte pairs (i outer, j inner), one pair per cycle.
module bpp_sched #(
  parameter int unsigned NB = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  output logic                  run,
  output logic [$clog2(NB)-1:0] idx_a,
  output logic [$clog2(NB)-1:0] idx_b,
  output logic                  last
);
  localparam int unsigned IW = $clog2(NB);
  localparam logic [IW-1:0] TOP = IW'(NB - 1);

  logic          run_q, run_d;
  logic [IW-1:0] ia_q, ia_d, ib_q, ib_d;

  always_comb begin
    run_d = run_q;
    ia_d  = ia_q;
    ib_d  = ib_q;
    if (go) begin
      run_d = 1'b1;
      ia_d  = '0;
      ib_d  = '0;
    end else if (run_q) begin
      if (ib_q == TOP) begin
        ib_d = '0;
        if (ia_q == TOP) begin
          run_d = 1'b0;
        end else begin
          ia_d = ia_q + 1'b1;
        end
      end else begin
        ib_d = ib_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ia_q  <= '0;
      ib_q  <= '0;
    end else begin
      run_q <= run_d;
      ia_q  <= ia_d;
      ib_q  <= ib_d;
    end
  end

  assign run   = run_q;
  assign idx_a = ia_q;
  assign idx_b = ib_q;
  assign last  = run_q && (ia_q == TOP) && (ib_q == TOP);
endmodule

// File: rtl/bpp_mul8.sv
// The single shared 8x8 unsigned multiplier.
module bpp_mul8
  import bpp_pkg::*;
(
  input  byte_t x,
  input  byte_t y,
  output pp_t   p
);
  always_comb begin
    p = pp_t'(x) * pp_t'(y);
  end
endmodule

// File: rtl/bpp_accum.sv
// Wide accumulator: adds one byte product at a byte offset, full-width carry.
module bpp_accum
  import bpp_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           en,
  input  pp_t                            pp,
  input  logic [$clog2(2*NB-1)-1:0]      off,
  output logic [2*NB*BYTE_W-1:0]         acc,
  output logic                           carry
);
  localparam int unsigned PW = 2 * NB * BYTE_W;
  localparam int unsigned OW = $clog2(2*NB-1);

  logic [PW-1:0] acc_q, acc_d;
  logic [PW:0]   addend;
  logic [PW:0]   sum;

  always_comb begin
    addend = {{(PW + 1 - PP_W){1'b0}}, pp} << {off, 3'b000};
    sum    = {1'b0, acc_q} + addend;
    acc_d  = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      acc_d = sum[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc   = acc_q;
  assign carry = en && sum[PW];

  logic unused_ok;
  assign unused_ok = ^OW;
endmodule

// File: rtl/bpp_mult.sv
module bpp_mult
  import bpp_pkg::*;
#(
  parameter int unsigned NB = 2  // operand bytes: 2 or 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*NB-1:0]        opa,
  input  logic [8*NB-1:0]        opb,
  output logic                   busy,
  output logic                   done,
  output logic [16*NB-1:0]       product
);
  localparam int unsigned W  = NB * BYTE_W;
  localparam int unsigned PW = 2 * W;
  localparam int unsigned IW = $clog2(NB);
  localparam int unsigned OW = $clog2(2*NB-1);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  logic          run, last, go;
  logic [IW-1:0] ia, ib;
  logic [OW-1:0] off;
  logic [W-1:0]  a_q, a_d, b_q, b_d;
  logic          done_q, done_d;
  byte_t         x_sel, y_sel;
  pp_t           pp;
  logic          acc_carry;

  // A new operation is taken only when idle.
  assign go = start && !run;

  bpp_sched #(.NB(NB)) sched_i (
    .clk  (clk),
    .rst_n(rst_q_n),
    .go   (go),
    .run  (run),
    .idx_a(ia),
    .idx_b(ib),
    .last (last)
  );

  // Byte views of the captured operands.
  byte_t a_byte [NB];
  byte_t b_byte [NB];
  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign a_byte[g] = a_q[BYTE_W*g +: BYTE_W];
    assign b_byte[g] = b_q[BYTE_W*g +: BYTE_W];
  end

  assign x_sel = a_byte[ia];
  assign y_sel = b_byte[ib];
  assign off   = OW'(ia) + OW'(ib);

  bpp_mul8 mul_i (
    .x(x_sel),
    .y(y_sel),
    .p(pp)
  );

  bpp_accum #(.NB(NB)) acc_i (
    .clk  (clk),
    .rst_n(rst_q_n),
    .clr  (go),
    .en   (run),
    .pp   (pp),
    .off  (off),
    .acc  (product),
    .carry(acc_carry)
  );

  // Operand capture and done pulse: next-state logic.
  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    if (go) begin
      a_d = opa;
      b_d = opb;
    end
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      a_q    <= '0;
      b_q    <= '0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      done_q <= done_d;
    end
  end

  assign busy = run;
  assign done = done_q;
endmodule

// File: rtl/bpp_mult_chk.sv
module bpp_mult_chk #(
  parameter int unsigned NB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [16*NB-1:0]  product,
  input logic              carry
);
  localparam int unsigned NN = NB * NB;
  localparam int unsigned CW = 8;

  // Cycles since the accepted start; a start while busy does not reset it.
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start && !busy) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == CW'(NN)));
  p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CW'(NN)));
  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_idle_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !done);
  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !carry);
endmodule

bind bpp_mult bpp_mult_chk #(.NB(NB)) chk_i (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .product(product),
  .carry  (acc_carry)
);

// File: tb/bpp_mult_tb_top.sv
`timescale 1ns/1ps
module bpp_mult_tb_top;
  localparam int unsigned NB = 2;
  localparam int unsigned W  = 8 * NB;
  localparam int unsigned PW = 2 * W;
  localparam int unsigned NN = NB * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  opa, opb;
  logic          busy, done;
  logic [PW-1:0] product;

  always #4 clk = ~clk;  // 125 MHz

  bpp_mult #(.NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .product(product)
  );

  typedef struct {
    logic [PW-1:0] exp;
    int            due;
    string         tag;
  } item_t;

  item_t         sb [$];
  int            cyc = 0;
  int            total = 0;
  int            bad = 0;
  bit            mon_en = 1'b0;
  bit            have_last = 1'b0;
  logic [PW-1:0] last_exp;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: issue one operation; optionally disturb the pins while busy.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag, input bit disturb);
    item_t it;
    while (busy) @(negedge clk);
    opa   = a;
    opb   = b;
    start = 1'b1;
    @(posedge clk);
    #1;
    it.exp = PW'(a) * PW'(b);
    it.due = cyc + NN;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R4 / R5: start pulses and new operand values during the run.
      opa   = ~a;
      opb   = b + 1'b1;
      start = 1'b1;
      @(negedge clk);
      opa   = a ^ W'(16'h5a5a);
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: compare results, timing and busy each falling edge.
  always @(negedge clk) begin
    if (mon_en) begin
      item_t it;
      bit exp_busy;
      exp_busy = (sb.size() != 0) && !done;
      chk(busy == exp_busy, "R3 busy", PW'(busy), PW'(exp_busy));
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 done without operation", PW'(done), '0);
        end else begin
          it = sb.pop_front();
          chk(product == it.exp, it.tag, product, it.exp);
          chk(cyc == it.due, "R2 latency", PW'(cyc), PW'(it.due));
          last_exp  = it.exp;
          have_last = 1'b1;
        end
      end else if (have_last && sb.size() == 0 && !busy) begin
        chk(product == last_exp, "R6 hold", product, last_exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    opa   = '0;
    opb   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state.
    chk(busy == 1'b0, "R7 busy", PW'(busy), '0);
    chk(done == 1'b0, "R7 done", PW'(done), '0);
    chk(product == '0, "R7 product", product, '0);
    mon_en = 1'b1;

    // Corner values, issued back to back (R10).
    issue('0, '0, "R9 zero*zero", 1'b0);
    issue('0, '1, "R9 zero*max", 1'b0);
    issue(W'(1), W'(1), "R9 one*one", 1'b0);
    issue(W'(1), '1, "R9 one*max", 1'b0);
    issue('1, W'(1), "R9 max*one", 1'b0);
    issue('1, '1, "R8 max*max", 1'b0);
    issue('1, '0, "R9 max*zero", 1'b0);
    issue({1'b1, {(W-1){1'b0}}}, '1, "R8 topbit*max", 1'b0);

    // Start while busy and operand changes during the run.
    issue(W'(16'h1234), W'(16'habcd), "R4 R5 disturbed run", 1'b1);
    issue('1, '1, "R4 R5 disturbed max", 1'b1);
    issue(W'(16'h00ff), W'(16'hff00), "R5 disturbed cross", 1'b1);

    // Random operands.
    for (int k = 0; k < 200; k++) begin
      issue(W'($urandom), W'($urandom), "R1 random", (k % 17) == 0);
    end

    // Drain, then let the idle hold checks run.
    while (sb.size() != 0 || busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(product == last_exp, "R6 final hold", product, last_exp);
    finish_run();
  end
endmodule